// File: doc/BRIEF.md
# SDRAM Periodic Refresh Sequencer

This block keeps an SDRAM device refreshed by borrowing the shared command bus at a steady rate. An interval timer runs freely from reset and expires once every `T_REFI` cycles. Each expiry marks a refresh as owed. The sequencer then raises a bus request to an external arbiter and waits for the grant, which may take any number of cycles.

Once it holds the bus, the block sends a precharge to every bank and waits out the row-precharge time. It then sends one auto-refresh and waits out the refresh cycle time. After that it drops its request. It requests the bus again only after the arbiter has withdrawn its grant.

The timer never stops or restarts while a grant is awaited, so the refresh rate does not drift. Expiries that fall while a refresh is already owed or in progress merge into one owed refresh. The command port consists of the three active-low strobes, a bank address and a row/column address. Every cycle that does not issue a command drives an idle (NOP) code on it.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, req_o is low and the strobes read idle ({ras_n,cas_n,we_n} = 111). The first request appears in cycle T_REFI+1 after reset is released, where cycle k is the state after the k-th clock edge with reset low.
- R2: The interval timer reloads at every expiry whatever the grant delay. While each refresh ends before the next expiry, requests rise in cycles T_REFI+1, 2*T_REFI+1, 3*T_REFI+1, and so on.
- R3: No code other than idle is driven while ack_i is low. Once raised, req_o stays high until the refresh work is done.
- R4: The first command after a grant is the precharge code {ras_n,cas_n,we_n} = 010 with address bit 10 set. It appears in the cycle after the cycle in which ack_i is first seen high.
- R5: The auto-refresh code {ras_n,cas_n,we_n} = 001 appears exactly T_RP+1 cycles after the precharge, with T_RP idle cycles between them.
- R6: req_o falls exactly T_RFC+1 cycles after the auto-refresh, with T_RFC idle cycles between them.
- R7: Only the idle, precharge and auto-refresh codes ever appear on the strobes.
- R8: After req_o falls, it stays low for as long as ack_i remains high, even when another refresh is owed. It rises again two cycles after ack_i is first seen low, if a refresh is owed.
- R9: Several expiries that fall while one refresh is owed or running add exactly one further refresh, not one per expiry.
- R10: The bank address is always zero. Every address bit except bit 10 is always zero, and bit 10 is set only during the precharge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_o | output | 1 | Request for the SDRAM command bus |
| ack_i | input | 1 | Grant from the bus arbiter |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write-enable strobe, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Row/column address; bit 10 selects all banks during precharge |

## Verification
The bench builds the block with a 13-bit address, a 2-bit bank address, T_RP = 3, T_REFI = 100 and T_RFC = 5. These values make each refresh sequence far shorter than the interval, so grant delays of 0, 7 and 40 cycles can be checked against a fixed request grid. The short interval also lets a single stalled grant of 230 cycles span two expiries, which exercises the merging of owed refreshes within a few hundred cycles. In that same stall, the arbiter keeps its grant for five cycles after the release, while a refresh is owed, to show that the request waits for the grant to fall.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

   // strobe code ordered {ras_n, cas_n, we_n}
   typedef enum logic [2:0] {
      CMD_AREF = 3'b001,
      CMD_PALL = 3'b010,
      CMD_IDLE = 3'b111
   } sdram_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ASK,
      ST_PALL,
      ST_TRP,
      ST_AREF,
      ST_TRFC,
      ST_YIELD
   } rfsh_state_e;

   localparam int ALL_BANK_BIT = 10;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
   parameter int PERIOD = 100
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("refresh_interval_timer: PERIOD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)             cnt <= RELOAD;
      else if (cnt == '0)  cnt <= RELOAD;
      else                 cnt <= cnt - 1'b1;
   end

   assign tick_o = (cnt == '0);

   // expiries are isolated single-cycle pulses
   p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o)
      else $error("tick lasted more than one cycle");

endmodule

// File: rtl/refresh_cmd_sequencer.sv
module refresh_cmd_sequencer
   import sdram_refresh_pkg::*;
#(
   parameter int T_RP  = 3,
   parameter int T_RFC = 5
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick_i,
   input  logic       ack_i,
   output logic       req_o,
   output sdram_cmd_e cmd_o
);
   localparam int WMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int WW   = (WMAX > 1) ? $clog2(WMAX + 1) : 1;

   generate
      if (T_RP < 1) begin : g_bad_trp
         $error("refresh_cmd_sequencer: T_RP must be at least 1");
      end
      if (T_RFC < 1) begin : g_bad_trfc
         $error("refresh_cmd_sequencer: T_RFC must be at least 1");
      end
   endgenerate

   rfsh_state_e   state;
   logic          owed;
   logic [WW-1:0] wcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         owed  <= 1'b0;
         wcnt  <= '0;
      end else begin
         if (tick_i)                          owed <= 1'b1;
         else if (state == ST_IDLE && owed)   owed <= 1'b0;

         case (state)
            ST_IDLE:  if (owed) state <= ST_ASK;
            ST_ASK:   if (ack_i) state <= ST_PALL;
            ST_PALL: begin
               state <= ST_TRP;
               wcnt  <= WW'(T_RP - 1);
            end
            ST_TRP: begin
               if (wcnt == '0) state <= ST_AREF;
               else            wcnt  <= wcnt - 1'b1;
            end
            ST_AREF: begin
               state <= ST_TRFC;
               wcnt  <= WW'(T_RFC - 1);
            end
            ST_TRFC: begin
               if (wcnt == '0) state <= ST_YIELD;
               else            wcnt  <= wcnt - 1'b1;
            end
            ST_YIELD: if (!ack_i) state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_o = (state == ST_ASK)  || (state == ST_PALL) || (state == ST_TRP) ||
              (state == ST_AREF) || (state == ST_TRFC);
      case (state)
         ST_PALL: cmd_o = CMD_PALL;
         ST_AREF: cmd_o = CMD_AREF;
         default: cmd_o = CMD_IDLE;
      endcase
   end

   // a sequence starts only when a refresh is owed
   p_start_needs_owed_r9: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && !owed && !tick_i) |=> (state == ST_IDLE))
      else $error("sequence started with nothing owed");

   // the sequencer yields only after the grant is gone
   p_yield_waits_ack_r8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_YIELD && ack_i) |=> (state == ST_YIELD))
      else $error("left yield while grant still high");

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
   import sdram_refresh_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BANK_W = 2,
   parameter int T_RP   = 3,
   parameter int T_REFI = 100,
   parameter int T_RFC  = 5
) (
   input  logic              clk,
   input  logic              rst,
   output logic              req_o,
   input  logic              ack_i,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [BANK_W-1:0] ba_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int WMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int GW   = $clog2(WMAX + 2) + 1;
   localparam logic [GW-1:0] GAP_TOP = '1;

   generate
      if (ADDR_W <= ALL_BANK_BIT) begin : g_bad_addr
         $error("sdram_refresh_seq: ADDR_W must exceed the all-bank bit index");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("sdram_refresh_seq: BANK_W must be at least 1");
      end
      if (T_REFI <= T_RP + T_RFC + 4) begin : g_bad_refi
         $error("sdram_refresh_seq: T_REFI too short for one refresh sequence");
      end
   endgenerate

   logic       tick;
   sdram_cmd_e cmd;

   refresh_interval_timer #(.PERIOD(T_REFI)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .tick_o (tick)
   );

   refresh_cmd_sequencer #(.T_RP(T_RP), .T_RFC(T_RFC)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick),
      .ack_i  (ack_i),
      .req_o  (req_o),
      .cmd_o  (cmd)
   );

   assign {ras_n_o, cas_n_o, we_n_o} = cmd;
   assign ba_o = '0;

   always_comb begin
      addr_o = '0;
      addr_o[ALL_BANK_BIT] = (cmd == CMD_PALL);
   end

   // ---------------- checker state: idle gap since the last command --------
   logic [GW-1:0] gap;
   logic [2:0]    last_code;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap       <= '0;
         last_code <= 3'b111;
      end else if ({ras_n_o, cas_n_o, we_n_o} != 3'b111) begin
         gap       <= '0;
         last_code <= {ras_n_o, cas_n_o, we_n_o};
      end else if (gap != GAP_TOP) begin
         gap <= gap + 1'b1;
      end
   end

   p_no_cmd_ungranted_r3: assert property (@(posedge clk) disable iff (rst)
      ({ras_n_o, cas_n_o, we_n_o} != 3'b111) |-> ack_i)
      else $error("command driven without grant");

   p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
      (req_o && !ack_i) |=> req_o)
      else $error("request dropped before grant");

   p_legal_code_r7: assert property (@(posedge clk) disable iff (rst)
      ({ras_n_o, cas_n_o, we_n_o} == 3'b111) ||
      ({ras_n_o, cas_n_o, we_n_o} == 3'b010) ||
      ({ras_n_o, cas_n_o, we_n_o} == 3'b001))
      else $error("illegal command code");

   p_aref_spacing_r5: assert property (@(posedge clk) disable iff (rst)
      ({ras_n_o, cas_n_o, we_n_o} == 3'b001) |->
         (last_code == 3'b010 && gap == GW'(T_RP)))
      else $error("auto-refresh not T_RP idle cycles after precharge");

   p_release_spacing_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(req_o) |-> (last_code == 3'b001 && gap == GW'(T_RFC)))
      else $error("request released at the wrong time");

   p_hold_low_r8: assert property (@(posedge clk) disable iff (rst)
      (!req_o && ack_i) |=> !req_o)
      else $error("request raised while grant still high");

   p_addr_clean_r10: assert property (@(posedge clk) disable iff (rst)
      (ba_o == '0) && ((addr_o & ~(ADDR_W'(1) << ALL_BANK_BIT)) == '0))
      else $error("stray address bits");

endmodule

// File: tb/test_sdram_refresh_seq.sv
module test_sdram_refresh_seq;
   localparam int ADDR_W = 13;
   localparam int BANK_W = 2;
   localparam int T_RP   = 3;
   localparam int T_REFI = 100;
   localparam int T_RFC  = 5;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              ack = 1'b0;
   logic              req, ras_n, cas_n, we_n;
   logic [BANK_W-1:0] ba;
   logic [ADDR_W-1:0] addr;

   sdram_refresh_seq #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .T_RP(T_RP), .T_REFI(T_REFI), .T_RFC(T_RFC)
   ) i_sdram_refresh_seq (
      .clk(clk), .rst(rst), .req_o(req), .ack_i(ack),
      .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr)
   );

   always #10 clk = ~clk;   // 50 MHz

   int cyc = 0;
   int checks = 0, errors = 0, mon_err = 0;
   int last_pre = -1, last_ref = -1, last_rise = -1, last_fall = -1;
   int ref_cnt = 0, rise_cnt = 0;
   logic req_q = 1'b0;
   bit done = 0;

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   // bus monitor, 4 ns after each edge
   always begin
      @(posedge clk);
      #4;
      if (!rst) begin
         if ({ras_n, cas_n, we_n} != 3'b111 && !ack) begin
            mon_err++; errors++; checks++;
            $display("FAIL R3: code %b with ack low at cycle %0d, expected 111",
                     {ras_n, cas_n, we_n}, cyc);
         end
         if (!({ras_n, cas_n, we_n} inside {3'b111, 3'b010, 3'b001})) begin
            mon_err++; errors++; checks++;
            $display("FAIL R7: illegal code %b at cycle %0d, expected 111/010/001",
                     {ras_n, cas_n, we_n}, cyc);
         end
         if ({ras_n, cas_n, we_n} == 3'b010) begin
            last_pre = cyc;
            if (addr != (ADDR_W'(1) << 10) || ba != '0) begin
               mon_err++; errors++; checks++;
               $display("FAIL R4: precharge addr %h ba %0d, expected addr %h ba 0",
                        addr, ba, ADDR_W'(1) << 10);
            end
         end else if (addr != '0 || ba != '0) begin
            mon_err++; errors++; checks++;
            $display("FAIL R10: addr %h ba %0d outside precharge, expected 0 0", addr, ba);
         end
         if ({ras_n, cas_n, we_n} == 3'b001) begin
            last_ref = cyc;
            ref_cnt++;
         end
         if (req && !req_q) begin last_rise = cyc; rise_cnt++; end
         if (!req && req_q) last_fall = cyc;
         req_q = req;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic smp();
      @(posedge clk);
      #5;
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      ack = 1'b0;
      repeat (3) @(negedge clk);
      check(req == 1'b0, "R1 req during reset", int'(req), 0);
      check({ras_n, cas_n, we_n} == 3'b111, "R1 idle code during reset",
            int'({ras_n, cas_n, we_n}), 7);
      rst = 1'b0;
      smp();
      check(req == 1'b0, "R1 req after reset", int'(req), 0);
      check({ras_n, cas_n, we_n} == 3'b111, "R1 idle code after reset",
            int'({ras_n, cas_n, we_n}), 7);
      check(addr == '0 && ba == '0, "R10 address after reset", int'(addr), 0);
   endtask

   task automatic t_wait_req(input int exp_cyc, input string tag);
      int guard = 0;
      do begin
         smp();
         guard++;
      end while (!req && guard < 3 * T_REFI);
      check(req == 1'b1, {tag, " request seen"}, int'(req), 1);
      check(cyc == exp_cyc, {tag, " request cycle"}, cyc, exp_cyc);
      check(last_rise == cyc, {tag, " rise recorded"}, last_rise, cyc);
   endtask

   task automatic t_grant(input int delay, input int hold, output int drop_cyc);
      int g, guard;
      for (int i = 0; i < delay; i++) begin
         smp();
         if (!req) check(1'b0, "R3 request held while waiting", int'(req), 1);
      end
      g = cyc;
      @(negedge clk);
      ack = 1'b1;
      guard = 0;
      do begin
         smp();
         guard++;
      end while (req && guard < 4 * (T_RP + T_RFC + 4));
      check(req == 1'b0, "R6 request released", int'(req), 0);
      check(last_pre == g + 1, "R4 precharge follows grant", last_pre, g + 1);
      check(last_ref - last_pre == T_RP + 1, "R5 precharge to refresh",
            last_ref - last_pre, T_RP + 1);
      check(last_fall - last_ref == T_RFC + 1, "R6 refresh to release",
            last_fall - last_ref, T_RFC + 1);
      for (int i = 0; i < hold; i++) begin
         smp();
         check(req == 1'b0, "R8 request low while grant high", int'(req), 0);
      end
      drop_cyc = cyc;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic t_fixed_grid();
      int d;
      t_wait_req(T_REFI + 1, "R1 first");
      t_grant(0, 0, d);
      t_wait_req(2 * T_REFI + 1, "R2 grid after zero delay");
      t_grant(7, 0, d);
      t_wait_req(3 * T_REFI + 1, "R2 grid after short delay");
      t_grant(40, 0, d);
      t_wait_req(4 * T_REFI + 1, "R2 grid after long delay");
   endtask

   task automatic t_merge_owed();
      int r, ref0, rise0, d;
      r = cyc;
      ref0 = ref_cnt;
      rise0 = rise_cnt;
      t_grant(2 * T_REFI + 30, 5, d);   // two expiries fall inside this stall
      smp();
      check(req == 1'b0, "R8 still low one cycle after grant drops", int'(req), 0);
      smp();
      check(req == 1'b1, "R9 owed refresh requested", int'(req), 1);
      check(cyc == d + 2, "R8 re-request timing", cyc, d + 2);
      t_grant(0, 0, d);
      t_wait_req(r + 3 * T_REFI, "R2 grid after merge");
      check(ref_cnt - ref0 == 2, "R9 refreshes across stall", ref_cnt - ref0, 2);
      check(rise_cnt - rise0 == 2, "R9 requests across stall", rise_cnt - rise0, 2);
   endtask

   always @(posedge clk) begin
      if (!done && cyc > 5000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: cycle %0d expected below 5000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int d;
      t_reset_state();
      t_fixed_grid();
      t_merge_owed();
      t_grant(3, 0, d);
      smp();
      check(mon_err == 0, "R7 monitor clean", mon_err, 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule